// File: doc/BRIEF.md
# Registered-Output Stream Shift Queue

This block is a first-in first-out queue between a producer and a consumer. Each side uses a stream handshake made of a valid signal and a back-pressure signal. A word moves across a port only on a rising clock edge where valid is high and back-pressure is low. Words are stored in a shift register that is written at slot 0 and read at a moving address. A separate output data register sits in front of the shift register and holds the oldest word.

The output data, the output valid and the input back-pressure are all driven straight from flip-flops. No combinational path therefore runs from one port to the other, so the queue can sit between two modules that each wait on their own flow control. When the queue is empty, an incoming word bypasses the shift register and goes directly into the output register. The queue holds at most `DEPTH` words: one in the output register and `DEPTH-1` in the shift register.

The next values of valid and back-pressure are worked out from the next controller state and then registered. The "full" flag is derived separately for each kind of transition rather than from a general address compare. Control state is cleared by an active-low asynchronous reset. The stored words are not reset.

Top module: `regout_shift_queue`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `dn_valid` is 0 and `up_stall` is 0.
- R2: An input word is accepted only at a rising edge where `up_valid` is 1 and `up_stall` is 0. A word offered while `up_stall` is 1 is not stored and never appears at the output.
- R3: A word accepted into an empty queue is presented on `dn_data` with `dn_valid` high in the cycle right after its accepting edge.
- R4: Accepted words leave on `dn_data` in acceptance order, each exactly once, with none dropped and none repeated.
- R5: `dn_valid` is 1 exactly when the queue holds at least one word. It is updated only at clock edges.
- R6: `up_stall` is 1 exactly when the queue holds `DEPTH` words.
- R7: A full queue with `dn_stall` low hands out its oldest word and accepts nothing on that edge. On the following cycle it holds `DEPTH-1` words and `up_stall` is 0.
- R8: With `up_valid` held at 1 and `dn_stall` held at 0, a word leaves on every cycle after the first accepted word, so the queue sustains one transfer per cycle.
- R9: While `dn_valid` is 1 and `dn_stall` is 1, the next cycle keeps `dn_valid` at 1 and `dn_data` unchanged.
- R10: A queue holding one word that hands it out with no new word accepted shows `dn_valid` at 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| up_data | input | WIDTH | Word offered by the producer |
| up_valid | input | 1 | Producer has a word on `up_data` |
| up_stall | output | 1 | Queue refuses input this cycle (registered full flag) |
| dn_data | output | WIDTH | Oldest stored word, meaningful only while `dn_valid` is 1 |
| dn_valid | output | 1 | Queue presents a word (registered) |
| dn_stall | input | 1 | Consumer refuses the presented word |

## Verification
The bench builds the queue with `DEPTH` = 4 and `WIDTH` = 8. A shallow queue reaches every controller region within a few cycles: empty, the single word held in the output register, the shift register at its base address, and the full point where the special-cased full flag must agree with the address. The four-entry size also lets a short hand-written vector table walk through fill, blocked input at full, combined consume-and-produce at middle occupancy and drain, each with a hand-computed occupancy. After that, a long random stretch and directed tests for reset, bypass, hold and throughput run against a reference FIFO model. Words carry an incrementing sequence number, so any drop or duplicate shows up as a data mismatch.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

  typedef enum logic [1:0] {
    QS_EMPTY = 2'd0,
    QS_ONE   = 2'd1,
    QS_MORE  = 2'd2
  } qs_state_e;

  // Address width for a shift register holding depth-1 words (at least 1 bit).
  function automatic int unsigned slot_addr_bits(input int unsigned depth);
    return (depth > 2) ? $clog2(depth - 1) : 1;
  endfunction

  // True when one more push from shift-register address 'a' fills the queue.
  function automatic logic push_fills(input int unsigned a, input int unsigned depth);
    return (depth > 2) && (a == depth - 3);
  endfunction

  // True when entering the shift register (address 0) already fills the queue.
  function automatic logic first_push_fills(input int unsigned depth);
    return depth == 2;
  endfunction

endpackage

// File: rtl/qsr_ctrl.sv
module qsr_ctrl
  import qsr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = slot_addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic          dn_stall,
  output qs_state_e     state,
  output logic [AW-1:0] addr,
  output logic          valid_q,
  output logic          full_q,
  output logic          take,
  output logic          give
);

  qs_state_e     state_n;
  logic [AW-1:0] addr_n;
  logic          full_n;

  assign take = up_valid && !full_q;
  assign give = valid_q && !dn_stall;

  always_comb begin
    state_n = state;
    addr_n  = addr;
    full_n  = full_q;
    unique case (state)
      QS_EMPTY: begin
        full_n = 1'b0;
        if (take) state_n = QS_ONE;
      end
      QS_ONE: begin
        full_n = 1'b0;
        if (take && !give) begin
          state_n = QS_MORE;
          addr_n  = '0;
          full_n  = first_push_fills(DEPTH);
        end else if (!take && give) begin
          state_n = QS_EMPTY;
        end
      end
      QS_MORE: begin
        if (take && !give) begin
          addr_n = addr + AW'(1);
          full_n = push_fills(int'(addr), DEPTH);
        end else if (!take && give) begin
          full_n = 1'b0;
          if (addr == '0) state_n = QS_ONE;
          else            addr_n  = addr - AW'(1);
        end
      end
      default: begin
        state_n = QS_EMPTY;
        addr_n  = '0;
        full_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= QS_EMPTY;
      addr    <= '0;
      valid_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      state   <= state_n;
      addr    <= addr_n;
      valid_q <= (state_n != QS_EMPTY);
      full_q  <= full_n;
    end
  end

  // R6: the per-transition full flag agrees with the address counter
  a_r6_full_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (state == QS_MORE && addr == AW'(DEPTH - 2)));
  a_r6_top_is_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QS_MORE && addr == AW'(DEPTH - 2)) |-> full_q);
  // R5: registered valid tracks the controller state
  a_r5_valid_state: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == (state != QS_EMPTY));
  // R10: single word handed out with nothing arriving empties the queue
  a_r10_one_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QS_ONE && give && !take) |=> (state == QS_EMPTY && !valid_q));
  // R7: a full queue that is not drained keeps its address
  a_r7_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !give) |=> (full_q && $stable(addr)));

endmodule

// File: rtl/qsr_store.sv
module qsr_store #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SLOTS = 7,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] slot [SLOTS];

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = SLOTS - 1; i > 0; i--) slot[i] <= slot[i-1];
      slot[0] <= wr_data;
    end
  end

  assign rd_data = slot[rd_addr];

endmodule

// File: rtl/qsr_outreg.sv
module qsr_outreg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             load_direct,
  input  logic             load_slot,
  input  logic [WIDTH-1:0] direct_data,
  input  logic [WIDTH-1:0] slot_data,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (load_direct)    q <= direct_data;
    else if (load_slot) q <= slot_data;
  end

endmodule

// File: rtl/regout_shift_queue.sv
module regout_shift_queue
  import qsr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] up_data,
  input  logic             up_valid,
  output logic             up_stall,
  output logic [WIDTH-1:0] dn_data,
  output logic             dn_valid,
  input  logic             dn_stall
);

  localparam int unsigned AW    = slot_addr_bits(DEPTH);
  localparam int unsigned SLOTS = DEPTH - 1;

  qs_state_e        st;
  logic [AW-1:0]    addr;
  logic             take, give;
  logic             ld_direct, ld_slot, push;
  logic [WIDTH-1:0] slot_rd;

  qsr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .dn_stall (dn_stall),
    .state    (st),
    .addr     (addr),
    .valid_q  (dn_valid),
    .full_q   (up_stall),
    .take     (take),
    .give     (give)
  );

  // Bypass into the output register when nothing older is waiting behind it.
  assign ld_direct = take && (st == QS_EMPTY || (st == QS_ONE && give));
  assign ld_slot   = give && (st == QS_MORE);
  assign push      = take && !ld_direct;

  qsr_store #(.WIDTH(WIDTH), .SLOTS(SLOTS), .AW(AW)) u_store (
    .clk     (clk),
    .push    (push),
    .wr_data (up_data),
    .rd_addr (addr),
    .rd_data (slot_rd)
  );

  qsr_outreg #(.WIDTH(WIDTH)) u_out (
    .clk         (clk),
    .load_direct (ld_direct),
    .load_slot   (ld_slot),
    .direct_data (up_data),
    .slot_data   (slot_rd),
    .q           (dn_data)
  );

  // R3: bypassed word shows up one cycle later
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ld_direct |=> (dn_valid && dn_data == $past(up_data)));
  // R9: stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_stall) |=> (dn_valid && $stable(dn_data)));
  // R2: nothing is stored while stalled
  a_r2_no_store_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    up_stall |-> (!push && !ld_direct));
  // R4: only one source loads the output register
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_direct && ld_slot));

endmodule

// File: tb/regout_shift_queue_bench.sv
`timescale 1ns/1ps
module regout_shift_queue_bench;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned WIDTH = 8;

  // {up_valid, dn_stall, expected occupancy after the edge}
  localparam logic [4:0] VEC [16] = '{
    5'b11_001, 5'b11_010, 5'b10_010, 5'b11_011,
    5'b11_100, 5'b11_100, 5'b10_011, 5'b01_011,
    5'b10_011, 5'b00_010, 5'b00_001, 5'b10_001,
    5'b00_000, 5'b00_000, 5'b10_001, 5'b00_000
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] up_data = '0;
  logic             up_valid = 1'b0;
  logic             up_stall;
  logic [WIDTH-1:0] dn_data;
  logic             dn_valid;
  logic             dn_stall = 1'b0;

  int               n_chk = 0;
  int               n_bad = 0;
  int               n_out = 0;
  logic [WIDTH-1:0] seq = '0;
  logic [WIDTH-1:0] mq [$];
  bit               done = 1'b0;

  always #5 clk = ~clk;

  regout_shift_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regout_shift_queue (
    .clk (clk), .rst_n (rst_n), .up_data (up_data), .up_valid (up_valid),
    .up_stall (up_stall), .dn_data (dn_data), .dn_valid (dn_valid),
    .dn_stall (dn_stall)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle from a falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic step(input logic v, input logic s, input string dtag);
    bit acc, prd;
    up_valid = v; dn_stall = s; up_data = seq;
    @(posedge clk);
    acc = v && (mq.size() < DEPTH);
    prd = (mq.size() > 0) && !s;
    if (prd) begin void'(mq.pop_front()); n_out++; end
    if (acc) begin mq.push_back(seq); seq++; end
    @(negedge clk);
    check(dn_valid == (mq.size() > 0), "R5 valid", 32'(dn_valid), 32'(mq.size() > 0));
    check(up_stall == (mq.size() == DEPTH), "R6 stall", 32'(up_stall), 32'(mq.size() == DEPTH));
    if (mq.size() > 0) check(dn_data == mq[0], dtag, 32'(dn_data), 32'(mq[0]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0; dn_stall = 1'b0;
    mq.delete();
    #1;
    check(dn_valid == 1'b0, "R1 valid in reset", 32'(dn_valid), 0);
    check(up_stall == 1'b0, "R1 stall in reset", 32'(up_stall), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dn_valid == 1'b0, "R1 valid after reset", 32'(dn_valid), 0);
    check(up_stall == 1'b0, "R1 stall after reset", 32'(up_stall), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] blocked;
    int               base;
    do_reset();

    // Vector table: hand-computed occupancy through fill, full, mixed, drain.
    foreach (VEC[i]) begin
      step(VEC[i][4], VEC[i][3], "R4 order (table)");
      check(mq.size() == int'(VEC[i][2:0]), "R2 table occupancy",
            32'(mq.size()), 32'(VEC[i][2:0]));
      check(dn_valid == (VEC[i][2:0] != 0), "R5 table valid",
            32'(dn_valid), 32'(VEC[i][2:0] != 0));
      check(up_stall == (VEC[i][2:0] == 3'(DEPTH)), "R6 table stall",
            32'(up_stall), 32'(VEC[i][2:0] == 3'(DEPTH)));
    end

    // R3: bypass into an empty queue, visible one cycle later.
    do_reset();
    step(1'b1, 1'b1, "R3 bypass data");
    check(dn_valid == 1'b1, "R3 bypass valid", 32'(dn_valid), 1);
    // R10: hand the lone word out with nothing arriving.
    step(1'b0, 1'b0, "R10 drain");
    check(dn_valid == 1'b0, "R10 empty after drain", 32'(dn_valid), 0);

    // R9: stalled output holds its word.
    step(1'b1, 1'b1, "R9 fill");
    step(1'b1, 1'b1, "R9 fill");
    held = dn_data;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, "R9 hold data");
      check(dn_data == held && dn_valid, "R9 stable", 32'(dn_data), 32'(held));
    end

    // R2 / R7: fill up, offer blocked words, then drain one at full.
    step(1'b1, 1'b1, "R2 fill");
    step(1'b1, 1'b1, "R2 fill");
    check(up_stall == 1'b1, "R6 full stall", 32'(up_stall), 1);
    blocked = seq;
    step(1'b1, 1'b1, "R2 blocked");
    step(1'b1, 1'b0, "R7 produce at full");
    check(up_stall == 1'b0 && mq.size() == DEPTH - 1, "R7 one slot freed",
          32'(up_stall), 0);
    check(seq == blocked, "R2 blocked word not taken", 32'(seq), 32'(blocked));
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, "R4 drain order");
    check(dn_valid == 1'b0, "R4 fully drained", 32'(dn_valid), 0);

    // R8: continuous flow, one word per cycle.
    base = n_out;
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, "R8 stream data");
    check(n_out - base == 19, "R8 throughput", 32'(n_out - base), 19);

    // Random patterns on both ports.
    for (int k = 0; k < 2000; k++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0),
           "R4 random order");

    // R1: reset in the middle of traffic.
    do_reset();
    step(1'b0, 1'b0, "R1 idle");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule